// File: doc/BRIEF.md
# BCD Calendar Clock with Update-Busy Window

This block keeps time of day and a calendar in packed BCD: seconds, minutes, hours (24-hour only), day of month, month, a two-digit year counted from 2000, and a weekday. A free-running enable `tick_en` pulses at 32.768 kHz. A prescaler divides it down to one update per second. All fields can be read and written through a plain synchronous byte bus with address, write data, a read strobe and a write strobe. Read data is registered.

In the tick interval just before each one-second update, a busy status bit is high. Software that sees busy low has most of a second in which to read a coherent snapshot or to rewrite fields. A write that lands in the same clock as an update still keeps the written value.

Six alarm compare registers (second through year) are checked against the time after every update. A match sets a sticky alarm flag, which software clears by writing 1 to it. The interrupt output is that flag gated by an enable bit. The register bus carries no stream data, so it has no valid/ready handshake: every access completes in one clock, and there is no back-pressure.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the clock is halted (control reads 0x00), the time reads 00:00:00, day 0x01, month 0x01, year 0x00, weekday 0x00, status reads 0x00, all alarm fields read 0x00 and `irq` is 0.
- R2: Control register 0x40 bit 0 is the run bit. While it is 0, or while `tick_en` is 0, neither the prescaler nor any time field advances. While it is 1, each `tick_en` pulse advances the prescaler by one, and 2^PRESCALE_W pulses make one seconds update.
- R3: Status register 0x44 bit 0 (busy) is 1 exactly while the prescaler sits at its last count, the tick just before a seconds update. The update happens on the next counted tick, after which busy is 0.
- R4: Seconds and minutes count 0x00 to 0x59 in BCD and wrap to 0x00 with a carry to the next field. Hours count 0x00 to 0x23 and wrap to 0x00 with a carry to the day.
- R5: The day wraps to 0x01 after 0x31 (months 01, 03, 05, 07, 08, 10, 12), after 0x30 (months 04, 06, 09, 11), and after 0x29 in February of a year divisible by 4 or 0x28 otherwise. The wrap carries into the month. The month wraps from 0x12 to 0x01 and carries into the year, which wraps from 0x99 to 0x00.
- R6: The weekday at 0x18 advances on every day carry and wraps from 6 to 0. Only bits 3:0 are stored, and bits 7:4 read as 0.
- R7: A bus write to a time field in the same clock as a seconds update leaves that field holding the written value. The other fields advance as that update dictates.
- R8: Time fields sit at 0x00 sec, 0x04 min, 0x08 hour, 0x0C day, 0x10 month, 0x14 year, 0x18 weekday. Alarm fields sit at 0x20 sec through 0x34 year, in the same order. A read strobe returns the addressed register on `bus_rdata` after the next clock edge and holds it there until the next read. An unmapped address reads 0x00.
- R9: Status bit 6 (alarm flag) sets in the clock after a seconds update when all six alarm fields equal the matching time fields. Writing 0x44 with bit 6 = 1 clears it, and writing bit 6 = 0 leaves it unchanged.
- R10: `irq` equals the alarm flag AND the enable at register 0x48 bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 32.768 kHz tick enable, one clock wide |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Alarm interrupt |

## Verification
The bench builds the block with PRESCALE_W = 2, so one second lasts four ticks. With that setting, every calendar carry (month ends, leap February, year wrap, weekday wrap) is reached in a few dozen clocks per case. The prescaler can also be parked at its last count, which makes the busy window and a write colliding with an update directly observable. Alarm match, write-1 clearing and the interrupt gating are then driven across real seconds updates.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FIELDS     = 7;
  localparam int ALM_FIELDS = 6;

  localparam logic [7:0] OFS_ALM0   = 8'h20;
  localparam logic [7:0] OFS_CTRL   = 8'h40;
  localparam logic [7:0] OFS_STATUS = 8'h44;
  localparam logic [7:0] OFS_INTEN  = 8'h48;
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_ALM_BIT  = 6;
  localparam int INTEN_ALM_BIT = 3;

  typedef enum logic [2:0] {
    FLD_SEC = 3'd0, FLD_MIN = 3'd1, FLD_HOUR = 3'd2, FLD_DAY = 3'd3,
    FLD_MON = 3'd4, FLD_YEAR = 3'd5, FLD_WDAY = 3'd6
  } field_e;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
    logic [3:0] wday;
  } cal_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] year);
    logic [7:0] yb;
    yb = bcd_to_bin(year);
    case (mon)
      8'h02:                      return (yb[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick_en,
  output logic busy,
  output logic step
);
  localparam logic [PRESCALE_W-1:0] LAST = {PRESCALE_W{1'b1}};

  logic [PRESCALE_W-1:0] cnt;

  assign busy = (cnt == LAST);
  assign step = run && tick_en && busy;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (run && tick_en) cnt <= cnt + 1'b1;
  end

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt)); // R2
  AST_WRAP_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en && cnt == LAST) |=> (cnt == '0)); // R3
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       wr_en,
  input  field_e     wr_field,
  input  logic [7:0] wr_data,
  output cal_t       now
);
  cal_t nxt;
  logic c_sec, c_min, c_hour, c_day, c_mon;

  always_comb begin
    c_sec  = (now.sec == 8'h59);
    c_min  = c_sec && (now.min == 8'h59);
    c_hour = c_min && (now.hour == 8'h23);
    c_day  = c_hour && (now.day == last_day(now.mon, now.year));
    c_mon  = c_day && (now.mon == 8'h12);
    nxt      = now;
    nxt.sec  = c_sec ? 8'h00 : bcd_inc(now.sec);
    if (c_sec)  nxt.min  = (now.min == 8'h59) ? 8'h00 : bcd_inc(now.min);
    if (c_min)  nxt.hour = (now.hour == 8'h23) ? 8'h00 : bcd_inc(now.hour);
    if (c_hour) begin
      nxt.day  = c_day ? 8'h01 : bcd_inc(now.day);
      nxt.wday = (now.wday >= 4'd6) ? 4'd0 : now.wday + 4'd1;
    end
    if (c_day)  nxt.mon  = c_mon ? 8'h01 : bcd_inc(now.mon);
    if (c_mon)  nxt.year = (now.year == 8'h99) ? 8'h00 : bcd_inc(now.year);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, day: 8'h01,
               mon: 8'h01, year: 8'h00, wday: 4'h0};
    end else begin
      if (step) now <= nxt;
      if (wr_en) begin
        case (wr_field)
          FLD_SEC:  now.sec  <= wr_data;
          FLD_MIN:  now.min  <= wr_data;
          FLD_HOUR: now.hour <= wr_data;
          FLD_DAY:  now.day  <= wr_data;
          FLD_MON:  now.mon  <= wr_data;
          FLD_YEAR: now.year <= wr_data;
          default:  now.wday <= wr_data[3:0];
        endcase
      end
    end
  end

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && now.sec == 8'h59) |=> (now.sec == 8'h00)); // R4
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_field == FLD_SEC) |=> (now.sec == $past(wr_data))); // R7
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  cal_t       now,
  input  logic       wr_en,
  input  logic [2:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic       clr,
  input  logic       irq_en,
  input  logic [2:0] rd_idx,
  output logic [7:0] rd_val,
  output logic       flag,
  output logic       irq
);
  logic [7:0] cmp [ALM_FIELDS];
  logic [7:0] cur [ALM_FIELDS];
  logic [ALM_FIELDS-1:0] hit;
  logic step_q, set_evt;

  assign cur[0] = now.sec;
  assign cur[1] = now.min;
  assign cur[2] = now.hour;
  assign cur[3] = now.day;
  assign cur[4] = now.mon;
  assign cur[5] = now.year;

  for (genvar i = 0; i < ALM_FIELDS; i++) begin : g_fld
    always_ff @(posedge clk) begin
      if (!rst_n)                         cmp[i] <= 8'h00;
      else if (wr_en && wr_idx == 3'(i))  cmp[i] <= wr_data;
    end
    assign hit[i] = (cmp[i] == cur[i]);
  end

  assign rd_val  = (rd_idx < 3'(ALM_FIELDS)) ? cmp[rd_idx] : 8'h00;
  assign set_evt = step_q && (&hit);
  assign irq     = flag && irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      step_q <= step;
      if (set_evt)  flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_evt) |=> !flag); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R9
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int PRESCALE_W = 15,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] TIME_END = ADDR_W'(4 * FIELDS);
  localparam logic [ADDR_W-1:0] ALM_BEG  = ADDR_W'(OFS_ALM0);
  localparam logic [ADDR_W-1:0] ALM_END  = ADDR_W'(OFS_ALM0) + ADDR_W'(4 * ALM_FIELDS);

  logic run, inten, busy, step, flag;
  logic in_time, in_alm, aligned;
  logic [2:0] idx;
  logic [7:0] alm_val, rd_mux;
  cal_t now;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign in_time = aligned && (bus_addr < TIME_END);
  assign in_alm  = aligned && (bus_addr >= ALM_BEG) && (bus_addr < ALM_END);
  assign idx     = 3'((bus_addr & ~ALM_BEG) >> 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      inten <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_W'(OFS_CTRL))  run   <= bus_wdata[0];
      if (bus_addr == ADDR_W'(OFS_INTEN)) inten <= bus_wdata[INTEN_ALM_BIT];
    end
  end

  rtc_prescaler #(.PRESCALE_W(PRESCALE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .tick_en(tick_en),
    .busy(busy), .step(step)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .step(step),
    .wr_en(bus_wr && in_time), .wr_field(field_e'(idx)),
    .wr_data(bus_wdata), .now(now)
  );

  rtc_alarm u_alm (
    .clk(clk), .rst_n(rst_n), .step(step), .now(now),
    .wr_en(bus_wr && in_alm), .wr_idx(idx), .wr_data(bus_wdata),
    .clr(bus_wr && bus_addr == ADDR_W'(OFS_STATUS) && bus_wdata[STAT_ALM_BIT]),
    .irq_en(inten), .rd_idx(idx), .rd_val(alm_val), .flag(flag), .irq(irq)
  );

  always_comb begin
    rd_mux = 8'h00;
    if (in_time) begin
      case (field_e'(idx))
        FLD_SEC:  rd_mux = now.sec;
        FLD_MIN:  rd_mux = now.min;
        FLD_HOUR: rd_mux = now.hour;
        FLD_DAY:  rd_mux = now.day;
        FLD_MON:  rd_mux = now.mon;
        FLD_YEAR: rd_mux = now.year;
        default:  rd_mux = {4'h0, now.wday};
      endcase
    end else if (in_alm) begin
      rd_mux = alm_val;
    end else if (bus_addr == ADDR_W'(OFS_CTRL)) begin
      rd_mux = {7'd0, run};
    end else if (bus_addr == ADDR_W'(OFS_STATUS)) begin
      rd_mux[STAT_BUSY_BIT] = busy;
      rd_mux[STAT_ALM_BIT]  = flag;
    end else if (bus_addr == ADDR_W'(OFS_INTEN)) begin
      rd_mux[INTEN_ALM_BIT] = inten;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R8
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !inten |-> !irq); // R10
endmodule

// File: tb/sim_bcd_rtc_core.sv
`timescale 1ns/1ps
module sim_bcd_rtc_core;
  localparam int PW = 2;
  localparam int TPS = 1 << PW;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b1;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_rtc_core #(.PRESCALE_W(PW), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(addr),
    .bus_wdata(wdata), .bus_wr(wr), .bus_rd(rd), .bus_rdata(rdata), .irq(irq)
  );

  // {sec,min,hour,day,mon,year,wday} before, then expected after one second
  localparam logic [111:0] VEC [12] = '{
    {56'h00_00_00_01_01_00_00, 56'h01_00_00_01_01_00_00},
    {56'h59_00_00_01_01_00_00, 56'h00_01_00_01_01_00_00},
    {56'h59_59_23_15_03_24_03, 56'h00_00_00_16_03_24_04},
    {56'h59_59_23_28_02_23_06, 56'h00_00_00_01_03_23_00},
    {56'h59_59_23_28_02_24_01, 56'h00_00_00_29_02_24_02},
    {56'h59_59_23_29_02_24_02, 56'h00_00_00_01_03_24_03},
    {56'h59_59_23_30_04_10_05, 56'h00_00_00_01_05_10_06},
    {56'h59_59_23_31_12_99_02, 56'h00_00_00_01_01_00_03},
    {56'h59_59_23_30_01_07_04, 56'h00_00_00_31_01_07_05},
    {56'h09_59_22_05_07_50_00, 56'h10_59_22_05_07_50_00},
    {56'h59_59_09_05_07_50_00, 56'h00_00_10_05_07_50_00},
    {56'h59_59_23_28_02_00_06, 56'h00_00_00_29_02_00_00}
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic br(input logic [7:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_ticks(input int n);
    bw(8'h40, 8'h01);
    repeat (n - 1) @(negedge clk);
    bw(8'h40, 8'h00);
  endtask

  task automatic set_time(input logic [55:0] t);
    for (int f = 0; f < 7; f++) bw(8'(4 * f), t[55 - 8*f -: 8]);
  endtask

  task automatic get_time(output logic [55:0] t);
    logic [7:0] v;
    for (int f = 0; f < 7; f++) begin
      br(8'(4 * f), v);
      t[55 - 8*f -: 8] = v;
    end
  endtask

  initial begin
    logic [7:0] v;
    logic [55:0] t;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    br(8'h40, v); chk("R1 ctrl", v, 8'h00);
    br(8'h44, v); chk("R1 status", v, 8'h00);
    get_time(t);  chk("R1 time", t, 56'h00_00_00_01_01_00_00);
    br(8'h34, v); chk("R1 alarm year", v, 8'h00);
    chk("R1 irq", irq, 1'b0);

    // R2 halted: no advance
    idle(20);
    br(8'h00, v); chk("R2 halted sec", v, 8'h00);
    // R2 running without tick enable: no advance
    bw(8'h40, 8'h01);
    tick_en = 1'b0;
    idle(12);
    bw(8'h40, 8'h00);
    tick_en = 1'b1;
    br(8'h00, v); chk("R2 no tick sec", v, 8'h00);
    br(8'h44, v); chk("R2 prescaler held", v, 8'h00);

    // R4 R5 R6 vector table
    for (int i = 0; i < 12; i++) begin
      set_time(VEC[i][111:56]);
      run_ticks(TPS);
      get_time(t);
      chk($sformatf("R4 R5 R6 vector %0d", i), t, VEC[i][55:0]);
    end

    // R3 busy window
    set_time(56'h30_00_00_01_01_00_00);
    run_ticks(TPS - 1);
    br(8'h44, v); chk("R3 busy at last count", v, 8'h01);
    br(8'h00, v); chk("R3 no update yet", v, 8'h30);
    run_ticks(1);
    br(8'h44, v); chk("R3 busy low after update", v, 8'h00);
    br(8'h00, v); chk("R3 updated", v, 8'h31);

    // R6 upper weekday bits
    bw(8'h18, 8'hF5);
    br(8'h18, v); chk("R6 weekday mask", v, 8'h05);

    // R7 write collides with update
    bw(8'h00, 8'h59); bw(8'h04, 8'h10);
    run_ticks(TPS - 1);
    bw(8'h40, 8'h01);
    bw(8'h00, 8'h42);
    bw(8'h40, 8'h00);
    br(8'h00, v); chk("R7 written sec kept", v, 8'h42);
    br(8'h04, v); chk("R7 minute carried", v, 8'h11);
    run_ticks(TPS - 1);

    // R8 readback and unmapped
    bw(8'h28, 8'h17);
    br(8'h28, v); chk("R8 alarm hour readback", v, 8'h17);
    br(8'h3C, v); chk("R8 unmapped", v, 8'h00);
    idle(3);
    chk("R8 rdata held", rdata, 8'h00);

    // R9 R10 alarm
    set_time(56'h45_30_12_10_06_25_02);
    bw(8'h20, 8'h46); bw(8'h24, 8'h30); bw(8'h28, 8'h12);
    bw(8'h2C, 8'h10); bw(8'h30, 8'h06); bw(8'h34, 8'h25);
    run_ticks(TPS);
    idle(1);
    br(8'h44, v); chk("R9 alarm flag set", v, 8'h40);
    chk("R10 irq off when disabled", irq, 1'b0);
    bw(8'h48, 8'h08);
    chk("R10 irq on when enabled", irq, 1'b1);
    bw(8'h44, 8'h00);
    br(8'h44, v); chk("R9 write 0 no clear", v, 8'h40);
    bw(8'h44, 8'h40);
    br(8'h44, v); chk("R9 write 1 clears", v, 8'h00);
    chk("R10 irq follows flag", irq, 1'b0);
    run_ticks(TPS);
    idle(1);
    br(8'h44, v); chk("R9 mismatch no flag", v, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule